// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol machine of a 256-byte serial EEPROM. It watches oversampled clock and data lines of a two-wire bus on its own system clock. It recognises start and stop conditions and decodes a device byte that carries the fixed `1010` prefix, the chip-select bits and a read/write flag. It acknowledges bytes by pulling the data line low through an open-drain enable.

For writes, the byte that follows the device byte loads the internal address counter. Each later data byte goes to a page buffer through a load strobe, and a stop then requests programming through a commit strobe. For reads, bytes are shifted out from the counter address. The host can chain bytes with acknowledges, and a repeated start after the word address turns a write into a random read.

A busy input from the storage side suppresses the device acknowledge, so the host can poll until programming has finished. The storage array, the page buffer and the programming timer sit outside this block.

Top module: `ee2w_slave`

## Requirements
- R1: Both bus inputs pass through a synchronizer before edge detection. `sda_oe_o` is 0 after reset and in the cycle after any stop is detected.
- R2: The device byte is received MSB first. The block acknowledges it only when bits 7:4 equal `1010`. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: Device-byte bits 3:1 must equal `dev_sel_i`, unless `sel_ignore_i` is 1, in which case any value is accepted. Bit 0 selects read (1) or write (0).
- R4: An acknowledge holds `sda_oe_o` at 1 from the SCL fall after the 8th bit to the SCL fall that ends the 9th clock. `sda_oe_o` changes only after an SCL fall, a start or a stop.
- R5: In a write, the second byte loads the address counter. Each later complete byte gives one single-cycle `ld_stb_o` pulse carrying the counter value on `ld_addr_o` and the byte on `ld_data_o`.
- R6: A stop after at least one data byte gives one single-cycle `commit_o` pulse. A stop with no data byte gives none.
- R7: While `busy_i` is 1, a matching device byte gets no acknowledge.
- R8: A read sends the byte at `rd_addr_o` MSB first and then increments the counter, wrapping from 255 to 0. A host acknowledge (SDA low on the 9th clock) asks for the next byte. A host no-acknowledge ends the read.
- R9: A repeated start after the word-address byte, followed by a read device byte, reads from the loaded address. It causes no load and no commit.
- R10: Between commands the counter holds the last accessed address plus one.
- R11: During a write, only counter bits 3:0 increment after each data byte, wrapping within the 16-byte page. Bits 7:4 stay fixed.
- R12: A start or stop inside a byte aborts the transfer. The partial byte causes no load and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_sel_i | input | 3 | Chip-select value compared with device-byte bits 3:1 |
| sel_ignore_i | input | 1 | 1 makes the chip-select bits don't-care |
| busy_i | input | 1 | Storage is programming; device byte is not acknowledged |
| rd_addr_o | output | 8 | Address counter, used as the read address |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| ld_stb_o | output | 1 | Page-buffer load strobe |
| ld_addr_o | output | 8 | Page-buffer load address |
| ld_data_o | output | 8 | Page-buffer load data |
| commit_o | output | 1 | Programming request |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except when it makes a start or stop. They also assume that each SCL phase lasts longer than the synchronizer delay, so that every bus edge is seen as one event. The host tasks in the bench keep each SCL phase at ten system cycles and move SDA only in the middle of the low phase. They make starts and stops only with SCL held high. The storage model in the bench reads combinationally, so `rd_data_i` always matches the current counter.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
   typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} st_e;
   typedef enum logic [1:0] {PH_DEV, PH_WADDR, PH_WDATA} ph_e;
   typedef enum logic [1:0] {CTR_HOLD, CTR_LOAD, CTR_INC_ALL, CTR_INC_PAGE} ctr_op_e;
   localparam logic [3:0] DEV_PREFIX = 4'b1010;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/ee2w_bus_sync.sv
module ee2w_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ee2w_bus_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_s, sda_s, scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s      = scl_pipe[STAGES-1];
   assign sda_s      = sda_pipe[STAGES-1];
   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee2w_addr_ctr.sv
module ee2w_addr_ctr
   import ee2w_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctr_op_e           op_i,
   input  logic [ADDR_W-1:0] load_val_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] ALL_ONE = ADDR_W'(1);
   logic [ADDR_W-1:0] addr_q, page_next;

   if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_next = addr_q + ALL_ONE;
   end else begin : g_paged
      localparam logic [PAGE_W-1:0] COL_ONE = PAGE_W'(1);
      logic [PAGE_W-1:0] col_next;
      assign col_next  = addr_q[PAGE_W-1:0] + COL_ONE;
      assign page_next = {addr_q[ADDR_W-1:PAGE_W], col_next};

      // R11
      page_row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == CTR_INC_PAGE) |=> (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else begin
         case (op_i)
            CTR_LOAD:     addr_q <= load_val_i;
            CTR_INC_ALL:  addr_q <= addr_q + ALL_ONE;
            CTR_INC_PAGE: addr_q <= page_next;
            default:      addr_q <= addr_q;
         endcase
      end
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
   import ee2w_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        dev_sel_i,
   input  logic              sel_ignore_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              ld_stb_o,
   output logic [ADDR_W-1:0] ld_addr_o,
   output logic [BYTE_W-1:0] ld_data_o,
   output logic              commit_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("ee2w_slave: ADDR_W must be 1..8");
   end
   if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
      $error("ee2w_slave: PAGE_W must be 1..ADDR_W");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   ee2w_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det));

   st_e               st;
   ph_e               ph;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              oe, rw, host_more, pend;
   ctr_op_e           ctr_op;
   logic [ADDR_W-1:0] ctr_val, ctr_addr;
   logic              dev_hit;

   ee2w_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .op_i(ctr_op), .load_val_i(ctr_val), .addr_o(ctr_addr));

   assign dev_hit = (rx_sh[7:4] == DEV_PREFIX)
                    && (sel_ignore_i || rx_sh[3:1] == dev_sel_i)
                    && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_DEV;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         oe        <= 1'b0;
         rw        <= 1'b0;
         host_more <= 1'b0;
         pend      <= 1'b0;
         ctr_op    <= CTR_HOLD;
         ctr_val   <= '0;
         ld_stb_o  <= 1'b0;
         ld_addr_o <= '0;
         ld_data_o <= '0;
         commit_o  <= 1'b0;
      end else begin
         ld_stb_o <= 1'b0;
         commit_o <= 1'b0;
         ctr_op   <= CTR_HOLD;
         if (stop_det) begin
            st       <= ST_IDLE;
            oe       <= 1'b0;
            commit_o <= pend;
            pend     <= 1'b0;
         end else if (start_det) begin
            st   <= ST_RX;
            ph   <= PH_DEV;
            cnt  <= '0;
            oe   <= 1'b0;
            pend <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && cnt != FULL) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + CNT_ONE;
                  end else if (scl_fall && cnt == FULL) begin
                     case (ph)
                        PH_DEV: begin
                           if (dev_hit) begin
                              oe <= 1'b1;
                              rw <= rx_sh[0];
                              st <= ST_RXACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        PH_WADDR: begin
                           oe      <= 1'b1;
                           st      <= ST_RXACK;
                           ctr_op  <= CTR_LOAD;
                           ctr_val <= rx_sh[ADDR_W-1:0];
                        end
                        default: begin
                           oe        <= 1'b1;
                           st        <= ST_RXACK;
                           ld_stb_o  <= 1'b1;
                           ld_addr_o <= ctr_addr;
                           ld_data_o <= rx_sh;
                           ctr_op    <= CTR_INC_PAGE;
                           pend      <= 1'b1;
                        end
                     endcase
                  end
               end
               ST_RXACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (ph == PH_DEV && rw) begin
                        tx_sh  <= rd_data_i;
                        oe     <= ~rd_data_i[BYTE_W-1];
                        ctr_op <= CTR_INC_ALL;
                        st     <= ST_TX;
                     end else begin
                        oe <= 1'b0;
                        st <= ST_RX;
                        ph <= (ph == PH_DEV) ? PH_WADDR : PH_WDATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + CNT_ONE;
                  end else if (scl_fall) begin
                     if (cnt == FULL) begin
                        oe <= 1'b0;
                        st <= ST_TXACK;
                     end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        oe    <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     host_more <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_more) begin
                        tx_sh  <= rd_data_i;
                        oe     <= ~rd_data_i[BYTE_W-1];
                        ctr_op <= CTR_INC_ALL;
                        cnt    <= '0;
                        st     <= ST_TX;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o  = oe;
   assign rd_addr_o = ctr_addr;

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);
   // R12
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o);
   // R4
   oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
   // R5
   ld_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb_o |=> !ld_stb_o);
   // R6
   commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_det));
   // R7
   dev_busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe_o) && st == ST_RXACK && ph == PH_DEV) |-> !$past(busy_i));
endmodule

// File: tb/ee2w_slave_tb_top.sv
module ee2w_slave_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       scl = 1'b1, host_low = 1'b0;
   logic       sda_oe, sel_ignore = 1'b0, busy = 1'b0;
   logic [2:0] dev_sel = 3'b000;
   logic [7:0] rd_addr, rd_data, ld_addr, ld_data;
   logic       ld_stb, commit;
   wire        sda_line = ~(host_low | sda_oe);

   logic [7:0] mem [256];
   logic [7:0] pbuf [256];
   logic       pmask [256];
   int         ld_cnt = 0, commit_cnt = 0, busy_left = 0;
   logic [7:0] ld_log [64];
   int total = 0, bad = 0;
   logic done = 1'b0;

   assign rd_data = mem[rd_addr];

   ee2w_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .dev_sel_i(dev_sel), .sel_ignore_i(sel_ignore), .busy_i(busy),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data), .ld_stb_o(ld_stb),
      .ld_addr_o(ld_addr), .ld_data_o(ld_data), .commit_o(commit));

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]   = 8'(i) ^ 8'h5A;
         pmask[i] = 1'b0;
         pbuf[i]  = 8'h00;
      end
   end

   always @(posedge clk) begin
      if (ld_stb) begin
         pbuf[ld_addr]  <= ld_data;
         pmask[ld_addr] <= 1'b1;
         ld_log[ld_cnt % 64] <= ld_addr;
         ld_cnt <= ld_cnt + 1;
      end
      if (commit) begin
         for (int i = 0; i < 256; i++) begin
            if (pmask[i]) mem[i] <= pbuf[i];
            pmask[i] <= 1'b0;
         end
         commit_cnt <= commit_cnt + 1;
         busy_left  <= 600;
         busy       <= 1'b1;
      end else if (busy_left > 0) begin
         busy_left <= busy_left - 1;
         if (busy_left == 1) busy <= 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_tx(input logic b);
      host_low = ~b; tick(5); scl = 1'b1; tick(10); scl = 1'b0; tick(5);
   endtask

   task automatic bit_rx(output logic b);
      host_low = 1'b0; tick(5); scl = 1'b1; tick(5); b = sda_line; tick(5); scl = 1'b0; tick(5);
   endtask

   task automatic bus_start();
      host_low = 1'b0; tick(5); scl = 1'b1; tick(5); host_low = 1'b1; tick(5); scl = 1'b0; tick(5);
   endtask

   task automatic bus_stop();
      host_low = 1'b1; tick(5); scl = 1'b1; tick(5); host_low = 1'b0; tick(10);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_tx(v[i]);
      bit_rx(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic more, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_rx(b);
         v[i] = b;
      end
      bit_tx(~more);
   endtask

   task automatic wait_ready();
      while (busy) tick(1);
      tick(4);
   endtask

   task automatic t_reset();
      chk("R1 oe after reset", sda_oe, 0);
      chk("R6 commit after reset", commit, 0);
      chk("R5 ld after reset", ld_stb, 0);
   endtask

   task automatic t_prefix();
      logic a;
      bus_start(); send_byte(8'hB0, a); chk("R2 bad prefix nack", a, 0);
      bus_stop();
      chk("R1 oe after stop", sda_oe, 0);
      bus_start(); send_byte(8'hA0, a); chk("R2 good prefix ack", a, 1);
      bus_stop();
   endtask

   task automatic t_select();
      logic a;
      dev_sel = 3'b101;
      bus_start(); send_byte(8'hA0, a); chk("R3 select mismatch nack", a, 0); bus_stop();
      bus_start(); send_byte(8'hAA, a); chk("R3 select match ack", a, 1); bus_stop();
      sel_ignore = 1'b1;
      bus_start(); send_byte(8'hA6, a); chk("R3 select ignored ack", a, 1); bus_stop();
      sel_ignore = 1'b0; dev_sel = 3'b000;
   endtask

   task automatic t_byte_write();
      logic a;
      int l0 = ld_cnt, c0 = commit_cnt;
      bus_start();
      send_byte(8'hA0, a); chk("R4 dev ack", a, 1);
      send_byte(8'h42, a); chk("R4 waddr ack", a, 1);
      send_byte(8'h3C, a); chk("R4 data ack", a, 1);
      chk("R5 one load", ld_cnt - l0, 1);
      chk("R5 load addr", ld_addr, 8'h42);
      chk("R5 load data", ld_data, 8'h3C);
      bus_stop();
      chk("R6 one commit", commit_cnt - c0, 1);
   endtask

   task automatic t_poll();
      logic a;
      int c0 = commit_cnt;
      bus_start(); send_byte(8'hA0, a); chk("R7 busy nack", a, 0); bus_stop();
      wait_ready();
      bus_start(); send_byte(8'hA0, a); chk("R7 ready ack", a, 1); bus_stop();
      chk("R6 no commit without data", commit_cnt - c0, 0);
   endtask

   task automatic rand_read(input logic [7:0] addr, output logic [7:0] v);
      logic a;
      bus_start(); send_byte(8'hA0, a); send_byte(addr, a);
      bus_start(); send_byte(8'hA1, a);
      recv_byte(1'b0, v);
      bus_stop();
   endtask

   task automatic cur_read(output logic [7:0] v);
      logic a;
      bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, v); bus_stop();
   endtask

   task automatic t_random_read();
      logic [7:0] v;
      int l0 = ld_cnt, c0 = commit_cnt;
      rand_read(8'h42, v);
      chk("R9 random read data", v, 8'h3C);
      chk("R9 no load", ld_cnt - l0, 0);
      chk("R9 no commit", commit_cnt - c0, 0);
      cur_read(v);
      chk("R10 current read next", v, 8'h43 ^ 8'h5A);
   endtask

   task automatic t_seq_wrap();
      logic a;
      logic [7:0] v;
      bus_start(); send_byte(8'hA0, a); send_byte(8'hFE, a);
      bus_start(); send_byte(8'hA1, a);
      recv_byte(1'b1, v); chk("R8 seq byte FE", v, 8'hFE ^ 8'h5A);
      recv_byte(1'b1, v); chk("R8 seq byte FF", v, 8'hFF ^ 8'h5A);
      recv_byte(1'b0, v); chk("R8 seq wrap to 00", v, 8'h00 ^ 8'h5A);
      bus_stop();
      cur_read(v);
      chk("R10 counter after seq", v, 8'h01 ^ 8'h5A);
   endtask

   task automatic t_page();
      logic a;
      logic [7:0] v;
      int l0 = ld_cnt;
      bus_start(); send_byte(8'hA0, a); send_byte(8'h1E, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
      bus_stop();
      chk("R11 load count", ld_cnt - l0, 3);
      chk("R11 addr 0", ld_log[l0 % 64], 8'h1E);
      chk("R11 addr 1", ld_log[(l0 + 1) % 64], 8'h1F);
      chk("R11 addr 2 page wrap", ld_log[(l0 + 2) % 64], 8'h10);
      wait_ready();
      cur_read(v);
      chk("R10 counter after page write", v, 8'h11 ^ 8'h5A);
      rand_read(8'h10, v);
      chk("R11 wrapped byte stored", v, 8'h33);
   endtask

   task automatic t_abort();
      logic a;
      logic [7:0] v;
      int l0 = ld_cnt, c0 = commit_cnt;
      bus_start(); send_byte(8'hA0, a); send_byte(8'h50, a);
      bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b1);
      bus_stop();
      chk("R12 stop abort no load", ld_cnt - l0, 0);
      chk("R12 stop abort no commit", commit_cnt - c0, 0);
      bus_start(); send_byte(8'hA0, a); send_byte(8'h60, a);
      bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b1);
      bus_start(); send_byte(8'hA1, a);
      recv_byte(1'b0, v);
      bus_stop();
      chk("R12 start abort reads old", v, 8'h60 ^ 8'h5A);
      chk("R12 start abort no load", ld_cnt - l0, 0);
      chk("R12 start abort no commit", commit_cnt - c0, 0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_prefix();
      t_select();
      t_byte_write();
      t_poll();
      t_random_read();
      t_seq_wrap();
      t_page();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule